// File: doc/BRIEF.md
# Trace Synchronization Request Controller

This block decides, for each direct or indirect branch that program trace reports, whether the outgoing branch message must be a full synchronizing message or may use the compressed form. It watches a set of event pulses that invalidate the trace decoder's view of the program: exit from system reset, program trace becoming enabled, return from a low-power state or from debug mode, a trace queue overrun, an event-in pin assertion (when configured), and a branch message that was lost to a secure-memory access or to a FIFO-entry collision.

Every such cause lands in one sticky pending flag. Two saturating counters can also force synchronization. One counts compressed trace messages sent since the last synchronizing message. The other counts sequential instructions since the last branch. When either counter reaches its limit of 255, the next branch must synchronize. A forced synchronization is released only by an accepted branch message. That message clears the pending flag and the message counter. A cause that arrives in the same cycle as that message stays pending for the branch after it.

The select output is combinational. It is valid in the cycle the branch strobe is high. Message formatting and queue storage live outside this block.

Top module: `trace_sync_ctrl`

## Requirements
- R1: After reset is released, `sync_pending` reads 1 and `sync_sel` reads 0. The first branch taken while `trace_en` is high selects sync.
- R2: In any cycle where `trace_en` is high after being low in the previous cycle, a branch in that cycle, or the first branch after it, selects sync.
- R3: A pulse on `lowpwr_exit` or `dbg_exit` makes the next enabled branch select sync.
- R4: A pulse on `q_overrun` sets `sync_pending`. A branch while `trace_en` is low neither selects sync nor clears `sync_pending`.
- R5: After 255 `msg_sent` pulses since the last sync branch, the next branch selects sync. After 254 pulses it does not.
- R6: The instruction counter counts `instr_step` pulses and is cleared by every branch. It saturates at 255, and at 255 the next branch selects sync. At 254 the next branch does not select sync.
- R7: An `evt_in` pulse forces sync only when `evt_cfg` equals 2'b01. The values 2'b00, 2'b10 and 2'b11 ignore it.
- R8: A pulse on `secure_loss` or `collide_loss` makes the next enabled branch select sync.
- R9: A branch that selects sync clears `sync_pending` and the message counter. If no new cause arrives, the following branch selects no sync.
- R10: A cause pulse in the same cycle as a sync branch leaves `sync_pending` set, so the following branch also selects sync.
- R11: A pulse on `reset_exit` makes the next enabled branch select sync.
- R12: `sync_sel` is 0 in every cycle where `branch` is low or `trace_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_en | input | 1 | Program trace enabled (level) |
| reset_exit | input | 1 | Pulse on exit from system reset |
| lowpwr_exit | input | 1 | Pulse on return from CPU low-power state |
| dbg_exit | input | 1 | Pulse on return from debug mode |
| q_overrun | input | 1 | Pulse on trace queue overrun |
| evt_in | input | 1 | Event-in pin assertion pulse |
| evt_cfg | input | 2 | Event-in control; 2'b01 enables sync on event |
| secure_loss | input | 1 | Branch message lost to secure access |
| collide_loss | input | 1 | Branch message lost to FIFO-entry collision |
| branch | input | 1 | Direct or indirect branch strobe |
| msg_sent | input | 1 | Compressed trace message emitted |
| instr_step | input | 1 | One sequential instruction executed |
| sync_sel | output | 1 | 1: this branch message carries sync |
| sync_pending | output | 1 | Registered sticky sync request |

## Verification
`sync_sel` is combinational. It is due in the same cycle as the branch strobe, so the bench drives inputs just after the falling edge and samples `sync_sel` 2 ns later, before the rising edge. Every cause, counter step and clear takes effect one rising edge later. Counts and pending state are therefore judged by a branch or a `sync_pending` sample in the cycle after the stimulus. The counter checks probe 254 and 255 steps to land on either side of the limit.

// File: rtl/trace_sync_ctrl.sv
module trace_sync_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trace_en,
  input  logic             reset_exit,
  input  logic             lowpwr_exit,
  input  logic             dbg_exit,
  input  logic             q_overrun,
  input  logic             evt_in,
  input  logic [1:0]       evt_cfg,
  input  logic             secure_loss,
  input  logic             collide_loss,
  input  logic             branch,
  input  logic             msg_sent,
  input  logic             instr_step,
  output logic             sync_sel,
  output logic             sync_pending
);
  localparam logic [CNT_W-1:0] LIM = '1;
  localparam logic [1:0] EVT_SYNC = 2'b01;

  logic             en_q;
  logic [CNT_W-1:0] msg_cnt, ins_cnt;

  wire en_rise   = trace_en & ~en_q;
  wire evt_hit   = evt_in & (evt_cfg == EVT_SYNC);
  wire new_cause = reset_exit | lowpwr_exit | dbg_exit | q_overrun |
                   evt_hit | secure_loss | collide_loss;
  wire need_sync = sync_pending | en_rise | (msg_cnt == LIM) | (ins_cnt == LIM);

  assign sync_sel = branch & trace_en & need_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q         <= 1'b0;
      sync_pending <= 1'b1;
      msg_cnt      <= '0;
      ins_cnt      <= '0;
    end else begin
      en_q <= trace_en;

      if (sync_sel) sync_pending <= new_cause;
      else          sync_pending <= sync_pending | new_cause | en_rise;

      if (sync_sel)                        msg_cnt <= '0;
      else if (msg_sent && msg_cnt != LIM) msg_cnt <= msg_cnt + 1'b1;

      if (branch)                            ins_cnt <= '0;
      else if (instr_step && ins_cnt != LIM) ins_cnt <= ins_cnt + 1'b1;
    end
  end
endmodule

module trace_sync_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trace_en,
  input logic       reset_exit,
  input logic       lowpwr_exit,
  input logic       dbg_exit,
  input logic       q_overrun,
  input logic       evt_in,
  input logic [1:0] evt_cfg,
  input logic       secure_loss,
  input logic       collide_loss,
  input logic       branch,
  input logic       sync_sel,
  input logic       sync_pending
);
  wire any_cause = reset_exit | lowpwr_exit | dbg_exit | q_overrun |
                   (evt_in & (evt_cfg == 2'b01)) | secure_loss | collide_loss;

  a_r12_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!branch || !trace_en) |-> !sync_sel);

  a_r3_exit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (lowpwr_exit || dbg_exit) |=> sync_pending);

  a_r8_loss_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (secure_loss || collide_loss) |=> sync_pending);

  a_r4_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    q_overrun |=> sync_pending);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_sel && !any_cause) |=> !sync_pending);

  a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_sel && any_cause) |=> sync_pending);

  a_r2_enable_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(trace_en) && branch) |-> sync_sel);

  a_r1_pending_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pending && branch && trace_en) |-> sync_sel);
endmodule

bind trace_sync_ctrl trace_sync_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .reset_exit(reset_exit),
  .lowpwr_exit(lowpwr_exit), .dbg_exit(dbg_exit), .q_overrun(q_overrun),
  .evt_in(evt_in), .evt_cfg(evt_cfg), .secure_loss(secure_loss),
  .collide_loss(collide_loss), .branch(branch), .sync_sel(sync_sel),
  .sync_pending(sync_pending)
);

// File: tb/trace_sync_ctrl_bench.sv
`timescale 1ns/1ps
module trace_sync_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trace_en = 1'b0;
  logic [6:0] cz = '0;
  logic evt_in = 1'b0;
  logic [1:0] evt_cfg = 2'b00;
  logic branch = 1'b0, msg_sent = 1'b0, instr_step = 1'b0;
  logic sync_sel, sync_pending;
  logic reset_exit, lowpwr_exit, dbg_exit, q_overrun, secure_loss, collide_loss, spare;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  assign {spare, collide_loss, secure_loss, q_overrun, dbg_exit, lowpwr_exit, reset_exit} = cz;

  localparam int C_RST = 0, C_LP = 1, C_DBG = 2, C_OVR = 3, C_SEC = 4, C_COL = 5;

  always #5 clk = ~clk;

  trace_sync_ctrl u_trace_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .reset_exit(reset_exit),
    .lowpwr_exit(lowpwr_exit), .dbg_exit(dbg_exit), .q_overrun(q_overrun),
    .evt_in(evt_in), .evt_cfg(evt_cfg), .secure_loss(secure_loss),
    .collide_loss(collide_loss), .branch(branch), .msg_sent(msg_sent),
    .instr_step(instr_step), .sync_sel(sync_sel), .sync_pending(sync_pending)
  );

  task automatic check(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic do_branch(input logic exp, input string what);
    branch = 1'b1;
    #2 check(sync_sel, exp, what);
    @(negedge clk) branch = 1'b0;
  endtask

  task automatic pulse(input int idx);
    cz = 7'(1 << idx);
    @(negedge clk) cz = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    #2 check(sync_pending, 1'b1, "R1 pending after reset");
    check(sync_sel, 1'b0, "R1 select idle after reset");
    trace_en = 1'b1;
    @(negedge clk);
    do_branch(1'b1, "R1 first branch syncs");
    do_branch(1'b0, "R9 next branch compressed");
  endtask

  task automatic t_enable;
    trace_en = 1'b0;
    @(negedge clk) trace_en = 1'b1;
    @(negedge clk);
    do_branch(1'b1, "R2 branch after enable");
    trace_en = 1'b0;
    @(negedge clk) trace_en = 1'b1;
    do_branch(1'b1, "R2 branch on enable cycle");
    do_branch(1'b0, "R2 later branch compressed");
  endtask

  task automatic t_exits;
    pulse(C_LP);
    do_branch(1'b1, "R3 low-power exit");
    do_branch(1'b0, "R3 cleared");
    pulse(C_DBG);
    idle(3);
    do_branch(1'b1, "R3 debug exit");
    pulse(C_RST);
    do_branch(1'b1, "R11 reset exit");
    do_branch(1'b0, "R11 cleared");
  endtask

  task automatic t_overrun;
    pulse(C_OVR);
    #2 check(sync_pending, 1'b1, "R4 overrun sets pending");
    trace_en = 1'b0;
    do_branch(1'b0, "R12 disabled branch no sync");
    #2 check(sync_pending, 1'b1, "R4 pending kept while disabled");
    trace_en = 1'b1;
    @(negedge clk);
    do_branch(1'b1, "R4 overrun honoured");
    do_branch(1'b0, "R4 cleared");
    #2 check(sync_sel, 1'b0, "R12 no branch no sync");
  endtask

  task automatic t_event;
    evt_cfg = 2'b00; evt_in = 1'b1;
    @(negedge clk) evt_in = 1'b0;
    do_branch(1'b0, "R7 cfg 00 ignored");
    evt_cfg = 2'b10; evt_in = 1'b1;
    @(negedge clk) evt_in = 1'b0;
    do_branch(1'b0, "R7 cfg 10 ignored");
    evt_cfg = 2'b11; evt_in = 1'b1;
    @(negedge clk) evt_in = 1'b0;
    #2 check(sync_pending, 1'b0, "R7 cfg 11 ignored");
    @(negedge clk);
    evt_cfg = 2'b01; evt_in = 1'b1;
    @(negedge clk) evt_in = 1'b0;
    do_branch(1'b1, "R7 cfg 01 syncs");
    evt_cfg = 2'b00;
  endtask

  task automatic t_loss;
    pulse(C_SEC);
    do_branch(1'b1, "R8 secure loss");
    pulse(C_COL);
    do_branch(1'b1, "R8 collision loss");
    do_branch(1'b0, "R8 cleared");
  endtask

  task automatic t_same_cycle;
    pulse(C_OVR);
    cz = 7'(1 << C_COL);
    do_branch(1'b1, "R10 clearing branch");
    cz = '0;
    do_branch(1'b1, "R10 cause kept");
    do_branch(1'b0, "R10 then cleared");
  endtask

  task automatic t_msg_cnt;
    for (int i = 0; i < 254; i++) begin
      msg_sent = 1'b1;
      @(negedge clk);
    end
    msg_sent = 1'b0;
    do_branch(1'b0, "R5 254 messages");
    msg_sent = 1'b1;
    @(negedge clk) msg_sent = 1'b0;
    do_branch(1'b1, "R5 255 messages");
    do_branch(1'b0, "R9 counter cleared");
  endtask

  task automatic t_instr(input int n, input logic exp, input string what);
    for (int i = 0; i < n; i++) begin
      instr_step = 1'b1;
      @(negedge clk);
    end
    instr_step = 1'b0;
    do_branch(exp, what);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_exits();
    t_overrun();
    t_event();
    t_loss();
    t_same_cycle();
    t_msg_cnt();
    t_instr(254, 1'b0, "R6 254 instructions");
    t_instr(255, 1'b1, "R6 255 instructions");
    t_instr(200, 1'b0, "R6 branch resets counter");
    t_instr(300, 1'b1, "R6 saturates");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule